// File: doc/BRIEF.md
# PLL Divider Reprogramming Sequencer

This block takes one new divider setting for a phase-locked loop and applies it in a safe order. First it moves the clock output mux onto the bypass reference. Next it holds the loop in reset and writes the encoded divider fields. It waits a settle time measured in clock cycles and then lets the loop out of reset. It then checks the lock flag once every poll interval, and it moves the mux back to the loop output only after lock has been seen. The analog loop sits outside the block and is reached only through the field, reset, mode and lock pins.

A request is a (nr, nf, no) triple on a valid/ready pair. `req_ready` is high only while the sequencer is idle. A request transfers on a cycle where `req_valid` and `req_ready` are both high. The requester must hold the triple steady until that cycle. While the sequencer is busy, `req_ready` stays low and any request offered is neither stored nor queued. Completion is marked by a single-cycle `done`, and `err` is high in that same cycle if the request was refused or lock never came.

The settle time is `CLK_MHZ*SETTLE_NS/1000` cycles. Lock is sampled every `POLL_CYC` cycles. When `LOCK_POLLS` is non-zero, the lock wait gives up after that many unsuccessful polls. A value of zero waits without limit.

Top module: `pll_prog_seq`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A request offered while busy is dropped: it causes no second field write and leaves the field outputs unchanged.
- R2: In the cycle after a valid request is accepted, the mode output is unchanged and `busy` is high. In the next cycle `mode_slow` is 1 and `pll_rst` is still 0. In the cycle after that `pll_rst` is 1.
- R3: In the cycle after `pll_rst` rises, `cfg_we` pulses for one cycle with both `mode_slow` and `pll_rst` high. From then on the fields hold `ref_div`=nr-1 (6 bits), `fb_div`=nf-1 (13 bits), `out_div`=no-1 (4 bits) and `bw_adj`=(nf>>1)-1 (12 bits). The fields change only in a `cfg_we` cycle.
- R4: `pll_rst` first reads 0 exactly SETTLE_CYC = CLK_MHZ*SETTLE_NS/1000 cycles after the `cfg_we` cycle.
- R5: Lock is sampled every POLL_CYC cycles after reset release, with the first sample POLL_CYC cycles after it. At the first sample that finds `lock_i` high, `mode_slow` falls to 0 and `done` rises in the same cycle, with `err` low.
- R6: When LOCK_POLLS consecutive polls find no lock, `done` and `err` rise LOCK_POLLS*POLL_CYC cycles after reset release. `mode_slow` stays 1 and `pll_rst` stays 0.
- R7: A request is refused if nr is 0, nf is below 2, or no is neither 1 nor an even value from 2 to 16. A refused request raises `done` and `err` in the cycle after acceptance and changes no mode, reset or field output.
- R8: `done` lasts exactly one cycle. `err` is never high without `done`.
- R9: A lock that first appears at the final allowed poll completes normally: `mode_slow` falls to 0 and `err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can transfer |
| req_nr | input | 6 | Reference divider value |
| req_nf | input | 13 | Feedback divider value |
| req_no | input | 5 | Output divider value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was a refusal or a lock timeout |
| mode_slow | output | 1 | 1 = mux on bypass reference, 0 = mux on loop output |
| pll_rst | output | 1 | Loop reset |
| cfg_we | output | 1 | Divider field write strobe |
| ref_div | output | 6 | Reference divider field |
| fb_div | output | 13 | Feedback divider field |
| out_div | output | 4 | Output divider field |
| bw_adj | output | 12 | Bandwidth adjust field |
| lock_i | input | 1 | Lock status from the loop |

## Verification
Two things can land on the same clock edge. One is the final poll of the lock wait, which would otherwise declare a timeout. The other is the lock flag rising for the first time. The bench's lock model raises lock a chosen number of cycles after reset release. Delays of 63 and 64 cycles with a 4-cycle poll and 16 polls place the first visible lock exactly on the last poll and one cycle past it. The first case must end with normal mode and no error. The second must end in timeout with the mux left on the bypass clock.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int NR_W = 6;
  localparam int NF_W = 13;
  localparam int NO_W = 5;
  localparam int OD_W = 4;
  localparam int BW_W = NF_W - 1;

  typedef struct packed {
    logic [NR_W-1:0] ref_f;
    logic [NF_W-1:0] fb_f;
    logic [OD_W-1:0] od_f;
    logic [BW_W-1:0] bw_f;
  } pll_fields_t;

  typedef enum logic [2:0] {
    S_IDLE, S_BYPASS, S_RESET, S_PROG, S_SETTLE, S_LOCK, S_FIN
  } seq_state_t;
endpackage

// File: rtl/pll_div_encode.sv
module pll_div_encode
  import pll_seq_pkg::*;
(
  input  logic [NR_W-1:0] nr_i,
  input  logic [NF_W-1:0] nf_i,
  input  logic [NO_W-1:0] no_i,
  output pll_fields_t     fields_o,
  output logic            ok_o
);
  localparam int NO_MAX = 1 << OD_W;

  logic no_ok;
  logic [BW_W-1:0] nf_half;

  always_comb begin
    no_ok = (no_i == NO_W'(1)) ||
            ((no_i[0] == 1'b0) && (no_i != '0) && (no_i <= NO_W'(NO_MAX)));
    ok_o  = no_ok && (nr_i != '0) && (nf_i >= NF_W'(2));
    nf_half          = nf_i[NF_W-1:1];
    fields_o.ref_f   = nr_i - NR_W'(1);
    fields_o.fb_f    = nf_i - NF_W'(1);
    fields_o.od_f    = OD_W'(no_i - NO_W'(1));
    fields_o.bw_f    = nf_half - BW_W'(1);
  end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (en && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);

  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (zero == ($past(load_val) == '0))); // R4
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int SETTLE_NS  = 10000,
  parameter int POLL_CYC   = 8,
  parameter int LOCK_POLLS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [NR_W-1:0] req_nr,
  input  logic [NF_W-1:0] req_nf,
  input  logic [NO_W-1:0] req_no,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            mode_slow,
  output logic            pll_rst,
  output logic            cfg_we,
  output logic [NR_W-1:0] ref_div,
  output logic [NF_W-1:0] fb_div,
  output logic [OD_W-1:0] out_div,
  output logic [BW_W-1:0] bw_adj,
  input  logic            lock_i
);
  localparam int SETTLE_RAW = CLK_MHZ * SETTLE_NS / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW > 1) ? SETTLE_RAW : 1;
  localparam int SET_W      = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int POLL_N     = (POLL_CYC > 1) ? POLL_CYC : 1;
  localparam int POLL_W     = (POLL_N > 1) ? $clog2(POLL_N) : 1;
  localparam int TMO_W      = (LOCK_POLLS > 1) ? $clog2(LOCK_POLLS) : 1;

  seq_state_t  state_q;
  pll_fields_t enc, pend_q, out_q;
  logic        enc_ok, err_q, mode_q, rst_q, we_q;
  logic        settle_zero, poll_zero, tmo;
  logic        settle_load, settle_en, poll_load, poll_en, lock_first, miss;

  pll_div_encode u_enc (
    .nr_i(req_nr), .nf_i(req_nf), .no_i(req_no), .fields_o(enc), .ok_o(enc_ok)
  );

  assign settle_load = (state_q == S_PROG);
  assign settle_en   = (state_q == S_SETTLE);
  assign lock_first  = (state_q == S_SETTLE) && settle_zero;
  assign miss        = (state_q == S_LOCK) && poll_zero && !lock_i;
  assign poll_load   = lock_first || miss;
  assign poll_en     = (state_q == S_LOCK);

  pll_seq_timer #(.W(SET_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(settle_load),
    .load_val(SET_W'(SETTLE_CYC - 1)), .en(settle_en), .zero(settle_zero)
  );

  pll_seq_timer #(.W(POLL_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .load(poll_load),
    .load_val(POLL_W'(POLL_N - 1)), .en(poll_en), .zero(poll_zero)
  );

  generate
    if (LOCK_POLLS > 0) begin : g_tmo
      logic [TMO_W-1:0] polls_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          polls_q <= '0;
        else if (lock_first) polls_q <= '0;
        else if (miss)       polls_q <= polls_q + TMO_W'(1);
      end
      assign tmo = (polls_q == TMO_W'(LOCK_POLLS - 1));
    end else begin : g_no_tmo
      assign tmo = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pend_q  <= '0;
      out_q   <= '0;
      err_q   <= 1'b0;
      mode_q  <= 1'b0;
      rst_q   <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          pend_q  <= enc;
          err_q   <= !enc_ok;
          state_q <= enc_ok ? S_BYPASS : S_FIN;
        end
        S_BYPASS: begin
          mode_q  <= 1'b1;
          state_q <= S_RESET;
        end
        S_RESET: begin
          rst_q   <= 1'b1;
          state_q <= S_PROG;
        end
        S_PROG: begin
          out_q   <= pend_q;
          we_q    <= 1'b1;
          state_q <= S_SETTLE;
        end
        S_SETTLE: begin
          we_q <= 1'b0;
          if (settle_zero) begin
            rst_q   <= 1'b0;
            state_q <= S_LOCK;
          end
        end
        S_LOCK: if (poll_zero) begin
          if (lock_i) begin
            mode_q  <= 1'b0;
            state_q <= S_FIN;
          end else if (tmo) begin
            err_q   <= 1'b1;
            state_q <= S_FIN;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign busy      = !req_ready;
  assign done      = (state_q == S_FIN);
  assign err       = done && err_q;
  assign mode_slow = mode_q;
  assign pll_rst   = rst_q;
  assign cfg_we    = we_q;
  assign ref_div   = out_q.ref_f;
  assign fb_div    = out_q.fb_f;
  assign out_div   = out_q.od_f;
  assign bw_adj    = out_q.bw_f;

  AST_FIELDS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(ref_div) || $changed(fb_div) || $changed(out_div) || $changed(bw_adj)) |-> cfg_we); // R1
  AST_RESET_AFTER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rst) |-> mode_slow && $past(mode_slow)); // R2
  AST_WRITE_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (mode_slow && pll_rst)); // R3
  AST_RELEASE_IN_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst) |-> mode_slow); // R4
  AST_NORMAL_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_slow) |-> ($past(lock_i) && done && !err)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_NO_WRITE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cfg_we && !pll_rst); // R1
endmodule

// File: tb/pll_prog_seq_tb.sv
module pll_prog_seq_tb;
  localparam int CLK_MHZ = 250, SETTLE_NS = 200, POLL = 4, POLLS = 16;
  localparam int SETTLE = CLK_MHZ * SETTLE_NS / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [5:0] req_nr = '0;
  logic [12:0] req_nf = '0;
  logic [4:0] req_no = '0;
  logic req_ready, busy, done, err, mode_slow, pll_rst, cfg_we;
  logic [5:0] ref_div;
  logic [12:0] fb_div;
  logic [3:0] out_div;
  logic [11:0] bw_adj;
  logic lock_i = 1'b0;
  int lock_delay = 0, lk_cnt = 0;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  pll_prog_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_NS(SETTLE_NS), .POLL_CYC(POLL), .LOCK_POLLS(POLLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_nr(req_nr), .req_nf(req_nf), .req_no(req_no), .busy(busy), .done(done),
    .err(err), .mode_slow(mode_slow), .pll_rst(pll_rst), .cfg_we(cfg_we),
    .ref_div(ref_div), .fb_div(fb_div), .out_div(out_div), .bw_adj(bw_adj), .lock_i(lock_i)
  );

  always @(negedge clk) begin
    if (pll_rst) begin
      lk_cnt = 0;
      lock_i = 1'b0;
    end else begin
      if (lk_cnt >= lock_delay) lock_i = 1'b1;
      lk_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit good(input int nr, input int nf, input int no);
    return (nr != 0) && (nf >= 2) && (no == 1 || (no % 2 == 0 && no >= 2 && no <= 16));
  endfunction

  task automatic run_op(input int nr, input int nf, input int no, input int delay, input bit poke);
    int p_ref, p_fb, p_od, p_bw, p_mode, writes, r_i, k, exp_j, j;
    bit seen;
    p_ref = ref_div; p_fb = fb_div; p_od = out_div; p_bw = bw_adj; p_mode = mode_slow;
    lock_delay = delay;
    @(negedge clk);
    chk("R1 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_nr = 6'(nr); req_nf = 13'(nf); req_no = 5'(no);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after accept", busy, 1);
    chk("R1 ready low while busy", req_ready, 0);
    if (!good(nr, nf, no)) begin
      chk("R7 refused done", done, 1);
      chk("R7 refused err", err, 1);
      chk("R7 mode untouched", mode_slow, p_mode);
      chk("R7 reset untouched", pll_rst, 0);
      chk("R7 ref field untouched", ref_div, p_ref);
      chk("R7 fb field untouched", fb_div, p_fb);
      chk("R7 out field untouched", out_div, p_od);
      chk("R7 bw field untouched", bw_adj, p_bw);
      @(negedge clk);
      chk("R8 done single cycle", done, 0);
      chk("R8 err without done", err, 0);
      return;
    end
    chk("R2 mode unchanged at accept", mode_slow, p_mode);
    chk("R8 no early done", done, 0);
    @(negedge clk);
    chk("R2 slow before reset", mode_slow, 1);
    chk("R2 reset still low", pll_rst, 0);
    @(negedge clk);
    chk("R2 reset after slow", pll_rst, 1);
    chk("R3 no write yet", cfg_we, 0);
    @(negedge clk);
    chk("R3 write strobe", cfg_we, 1);
    chk("R3 ref=nr-1", ref_div, nr - 1);
    chk("R3 fb=nf-1", fb_div, nf - 1);
    chk("R3 out=no-1", out_div, no - 1);
    chk("R3 bw=(nf>>1)-1", bw_adj, (nf >> 1) - 1);
    writes = 0; r_i = -1; seen = 0;
    for (int i = 1; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (poke && i == 10) begin
        req_valid = 1'b1; req_nr = 6'd9; req_nf = 13'd100; req_no = 5'd2;
      end
      if (poke && i == 11) req_valid = 1'b0;
      if (cfg_we) writes++;
      if (!pll_rst) begin seen = 1; r_i = i; end
    end
    chk("R4 settle cycles", r_i, SETTLE);
    chk("R1 single write", writes, 0);
    k = (delay + POLL) / POLL;
    exp_j = (k <= POLLS) ? POLL * k : POLL * POLLS;
    j = 0;
    for (int i = 1; i < 400; i++) begin
      if (done) break;
      @(negedge clk);
      if (cfg_we) writes++;
      j = i;
    end
    if (k <= POLLS) begin
      chk(delay == 63 ? "R9 last-poll lock timing" : "R5 lock to normal timing", j, exp_j);
      chk(delay == 63 ? "R9 last-poll mode normal" : "R5 mode normal", mode_slow, 0);
      chk(delay == 63 ? "R9 last-poll no err" : "R5 no err", err, 0);
    end else begin
      chk("R6 timeout timing", j, exp_j);
      chk("R6 timeout err", err, 1);
      chk("R6 mode stays slow", mode_slow, 1);
      chk("R6 reset released", pll_rst, 0);
    end
    chk("R1 no extra write", writes, 0);
    chk("R1 ref held after busy request", ref_div, nr - 1);
    chk("R1 fb held after busy request", fb_div, nf - 1);
    @(negedge clk);
    chk("R8 done single cycle", done, 0);
    chk("R8 err without done", err, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int nr, nf, no, idx;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R1 reset ready", req_ready, 1);
    chk("R8 reset done", done, 0);
    chk("R2 reset mode", mode_slow, 0);
    chk("R2 reset pll_rst", pll_rst, 0);
    chk("R3 reset write", cfg_we, 0);
    rst_n = 1'b1;
    run_op(1, 75, 1, 5, 0);
    run_op(3, 200, 2, 9, 1);
    run_op(2, 100, 3, 0, 0);
    run_op(2, 100, 0, 0, 0);
    run_op(2, 100, 18, 0, 0);
    run_op(0, 100, 2, 0, 0);
    run_op(2, 1, 2, 0, 0);
    run_op(1, 2, 16, 0, 0);
    run_op(63, 8191, 4, 1, 0);
    run_op(5, 333, 6, 63, 0);
    run_op(5, 333, 6, 64, 0);
    run_op(4, 500, 2, 7, 0);
    for (int n = 0; n < 30; n++) begin
      nr = 1 + int'($urandom % 63);
      nf = 2 + int'($urandom % 8190);
      idx = int'($urandom % 9);
      no = (idx == 0) ? 1 : idx * 2;
      if ($urandom % 5 == 0) no = 3 + 2 * int'($urandom % 14);
      run_op(nr, nf, no, int'($urandom % 51), ($urandom % 4) == 0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule